// File: doc/BRIEF.md
# Saturating Up/Down Bit-Slice Counter

This block is a synchronous binary counter that moves up or down by one per enabled clock. It stops at its end values instead of wrapping. Counting up, it holds at all ones. Counting down, it holds at zero. This makes it a safe position or level accumulator, because a value that runs past a limit can never jump to the opposite extreme.

The counter is a chain of identical one-bit slices, one per bit of the count. All slices share one clock, so every bit updates on the same edge. A carry runs through the chain and starts from the count enable. In up mode each slice passes the carry on while its bit is one; in down mode it passes the carry on while its bit is zero. A single end-of-chain control cell receives the carry that leaves the top slice. That carry can only be high when the next step would overflow or underflow, so the control cell turns it into a freeze that blocks every slice from toggling on that edge.

Freeze is decided from the current count and the current inputs before the edge. It is never a gated clock, so no extra step can slip through. It is also driven out as a status flag.

Top module: `sat_updown_counter`

## Requirements
- R1: With en=1 and dir_up=1, a count of all ones stays all ones on the next edge; it never wraps to zero.
- R2: With en=1 and dir_up=0, a count of zero stays zero on the next edge; it never wraps to all ones.
- R3: With en=1, dir_up=1 and the count below all ones, the count rises by exactly one on the next edge.
- R4: With en=1, dir_up=0 and the count above zero, the count falls by exactly one on the next edge.
- R5: With en=0 and rst=0, the count is unchanged on the next edge whatever dir_up is.
- R6: frozen is 1 in the same cycle exactly when en=1 and the count is at the end value for the present direction: all ones when dir_up=1, zero when dir_up=0. Otherwise it is 0.
- R7: While held at an end value, flipping dir_up (with en=1) drops frozen at once and moves the count one step away from the end value on the next edge.
- R8: rst=1 at an edge loads zero, whatever en and dir_up are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset to zero, active high |
| en | input | 1 | Count enable, feeds the carry into the lowest slice |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| count | output | WIDTH | Present count value |
| frozen | output | 1 | High when an enabled step would pass an end value |

## Verification
The bench builds two copies. One has WIDTH=4: both end values are reached within sixteen steps, so long stays at each limit and reversals there fit into a short run. The other has WIDTH=1: it checks the degenerate chain, where the single slice is both the lowest and the top cell and every step hits a limit. Both copies follow a clamped add/subtract model under random enable, direction and occasional reset. In that stimulus, direction changes are rare so that runs against the limits are long.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        logic val;
    } slice_state_t;

endpackage

// File: rtl/sat_cnt_slice.sv
module sat_cnt_slice
    import sat_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dir_e dir,
    input  logic carry_in,
    input  logic freeze,
    output logic bit_o,
    output logic carry_out
);

    slice_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = 1'b0;
        end else if (carry_in && !freeze) begin
            st_d.val = ~st_q.val;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // pass the carry while this bit is at its end value for the direction
    assign carry_out = carry_in & ((dir == DIR_UP) ? st_q.val : ~st_q.val);
    assign bit_o     = st_q.val;

endmodule

// File: rtl/sat_cnt_term.sv
module sat_cnt_term (
    input  logic top_carry,
    output logic freeze
);

    // carry leaving the top slice means the next step would cross a limit
    assign freeze = top_carry;

endmodule

// File: rtl/sat_updown_counter.sv
module sat_updown_counter
    import sat_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count,
    output logic             frozen
);

    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;
    logic              freeze;
    dir_e              dir;

    assign dir      = dir_e'(dir_up);
    assign carry[0] = en;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        sat_cnt_slice u_slice (
            .clk       (clk),
            .rst       (rst),
            .dir       (dir),
            .carry_in  (carry[i]),
            .freeze    (freeze),
            .bit_o     (count[i]),
            .carry_out (carry[i+1])
        );
    end

    sat_cnt_term u_term (
        .top_carry (carry[NCARRY-1]),
        .freeze    (freeze)
    );

    assign frozen = freeze;

endmodule

// File: rtl/sat_cnt_chk.sv
module sat_cnt_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             dir_up,
    input logic [WIDTH-1:0] count,
    input logic             frozen
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // R1
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir_up && count == TOP) |=> (count == TOP));

    // R2
    down_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !dir_up && count == '0) |=> (count == '0));

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir_up && !frozen) |=> (count == WIDTH'($past(count) + 1'b1)));

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !dir_up && !frozen) |=> (count == WIDTH'($past(count) - 1'b1)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(count));

    // R6
    frozen_flag_chk: assert property (@(posedge clk) disable iff (rst)
        frozen == (en && (dir_up ? (count == TOP) : (count == '0))));

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (count == '0));

endmodule

bind sat_updown_counter sat_cnt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .dir_up (dir_up),
    .count  (count),
    .frozen (frozen)
);

// File: tb/tb_sat_updown_counter.sv
module tb_sat_updown_counter;

    localparam int PERIOD = 10;
    localparam int W      = 4;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // vector fields: {rst, en, dir_up, frozen before edge, count after edge}
    localparam int NVEC = 12;
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd1},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd2},
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd1},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd0},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd0},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd1},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd1},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd0},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd0},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd1}
    };

    logic         clk = 1'b0;
    logic         rst, en, dir_up;
    logic [W-1:0] count;
    logic         frozen;
    logic [0:0]   count1;
    logic         frozen1;

    int tests  = 0;
    int failed = 0;

    logic [W-1:0] m4;
    logic [0:0]   m1;

    always #(PERIOD/2) clk = ~clk;

    sat_updown_counter #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up),
        .count(count), .frozen(frozen)
    );

    sat_updown_counter #(.WIDTH(1)) dut_w1 (
        .clk(clk), .rst(rst), .en(en), .dir_up(dir_up),
        .count(count1), .frozen(frozen1)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, check frozen, then check count at the next falling edge
    task automatic step(input logic r, input logic e, input logic d,
                        input logic exp_frz, input logic [W-1:0] exp_cnt,
                        input string req);
        rst = r; en = e; dir_up = d;
        #1;
        chk({req, " frozen"}, int'(frozen), int'(exp_frz));
        @(negedge clk);
        chk({req, " count"}, int'(count), int'(exp_cnt));
    endtask

    function automatic logic [W-1:0] next4(logic r, logic e, logic d, logic [W-1:0] v);
        if (r) return '0;
        if (!e) return v;
        if (d) return (v == TOP) ? v : v + 1'b1;
        return (v == '0) ? v : v - 1'b1;
    endfunction

    function automatic logic [0:0] next1(logic r, logic e, logic d, logic [0:0] v);
        if (r) return 1'b0;
        if (!e) return v;
        return d ? 1'b1 : 1'b0;
    endfunction

    initial begin
        #(PERIOD * 200000);
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b1; dir_up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R8 reset state with enable high
        chk("R8 reset count", int'(count), 0);
        chk("R8 reset count w1", int'(count1), 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0],
                 $sformatf("R6 vec%0d", i));
        end

        // R3 full climb from zero
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0, "R8 clear");
        for (int i = 1; i <= 15; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, W'(i), $sformatf("R3 up%0d", i));
        end
        // R1 long hold at all ones
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, TOP, "R1 hold top");
        end
        // R5 idle at top, both directions
        step(1'b0, 1'b0, 1'b1, 1'b0, TOP, "R5 idle up");
        step(1'b0, 1'b0, 1'b0, 1'b0, TOP, "R5 idle down");
        // R7 reverse at top, then return
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'd14, "R7 leave top");
        step(1'b0, 1'b1, 1'b1, 1'b0, TOP, "R3 back to top");
        // R4 full descent
        for (int i = 14; i >= 0; i--) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, W'(i), $sformatf("R4 down%0d", i));
        end
        // R2 long hold at zero
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R2 hold zero");
        end
        // R7 reverse at zero
        step(1'b0, 1'b1, 1'b1, 1'b0, 4'd1, "R7 leave zero");
        // R8 reset overrides an enabled up step
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R8 reset override");

        // random run against clamped models for both widths
        m4 = count;
        m1 = count1;
        dir_up = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            logic r, e, d;
            logic efr4, efr1;
            r = ($urandom_range(63) == 0);
            e = ($urandom_range(7) != 0);
            d = ($urandom_range(15) == 0) ? ~dir_up : dir_up;
            rst = r; en = e; dir_up = d;
            efr4 = e && (d ? (m4 == TOP) : (m4 == '0));
            efr1 = e && (d ? (m1 == 1'b1) : (m1 == 1'b0));
            #1;
            chk("R6 random frozen", int'(frozen), int'(efr4));
            chk("R6 random frozen w1", int'(frozen1), int'(efr1));
            m4 = next4(r, e, d, m4);
            m1 = next1(r, e, d, m1);
            @(negedge clk);
            chk("R1 R2 R3 R4 R5 R8 random count", int'(count), int'(m4));
            chk("R1 R2 R3 R4 R5 R8 random count w1", int'(count1), int'(m1));
        end

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule